// File: doc/BRIEF.md
# Two-Wire Controller Interrupt Vector Unit

This block gathers the single-cycle event pulses of a two-wire bus controller into sticky pending flags. It gates them with a software enable mask and reports one event at a time as a small numeric code. An interrupt handler reads the code register in a loop. Each read hands back the most urgent enabled event and retires it, so the next one appears on the following cycle. The loop ends when the register returns 0.

Two of the flags follow the data path rather than the code register. These are receive-ready and transmit-ready. They stay pending until the data side signals that the byte was taken or supplied. Two bus-level conditions are shown in the status register as live levels and never produce a code: the receiver shift register being full, and the bus being busy.

Top module: `twi_irq_vector`

## Requirements
- R1: After reset all pending flags and all mask bits are 0, the code output is 0 and `irq` is low.
- R2: A pulse on `evt[i]` sets pending flag i on the next cycle, whether or not mask bit i is set. The bit mapping is: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: The code is i+1 for the lowest index i that is both pending and enabled, so arbitration lost (code 1) beats every other event and addressed-as-slave (code 7) is served last.
- R4: When no pending flag is enabled, the code is 0 and `irq` is low. `irq` is high exactly when the code is nonzero.
- R5: Writing the status register clears every pending flag whose write-data bit is 1 and leaves flags written with 0 unchanged.
- R6: Reading the code register (address 2) returns the current code. For codes 1, 2, 3, 6 and 7 the read also clears that flag, so the next enabled pending event is shown one cycle later.
- R7: A code-register read does not clear receive-ready (flag 3) or transmit-ready (flag 4). A `rx_taken` pulse clears flag 3 and a `tx_loaded` pulse clears flag 4.
- R8: Status bit 11 follows `rx_shift_full` and status bit 12 follows `bus_busy`. Writes do not change them and they never produce a code.
- R9: When an event pulse and a clear for the same flag fall in the same cycle, the flag ends up set.
- R10: The address map is as follows. Address 0 is the mask: bits 6:0 are read/write and the upper bits read 0. Address 1 is status, with flags in bits 6:0. Address 2 is the code register: it is read-only and writes to it are ignored. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | 7 | Single-cycle event pulses, bit mapping as in R2 |
| rx_taken | input | 1 | Receive byte consumed, clears receive-ready |
| tx_loaded | input | 1 | Transmit byte supplied, clears transmit-ready |
| rx_shift_full | input | 1 | Receiver shift register full (level) |
| bus_busy | input | 1 | Bus busy (level) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from current state |
| irq_code | output | 3 | Current code, 0 when idle |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit data word and a 2-bit address. The 16-bit word is wide enough to show both level bits (11 and 12) next to the seven flags. The 2-bit address reaches all four slots, including the unused one. With these widths the bench drains a full set of simultaneous events through the read loop in priority order. It also shows masked events waiting silently, the data-path flags surviving code reads, and a clear losing to a same-cycle event.

// File: rtl/twi_irq_vector.sv
module twi_irq_vector #(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    evt,
  input  logic          rx_taken,
  input  logic          tx_loaded,
  input  logic          rx_shift_full,
  input  logic          bus_busy,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [2:0]    irq_code,
  output logic          irq
);
  localparam int NEV = 7;
  localparam int RSF_BIT = 11;
  localparam int BB_BIT = 12;
  localparam logic [AW-1:0] A_MASK = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_CODE = AW'(2);
  localparam logic [NEV-1:0] DATA_EV = 7'b0011000;

  logic [NEV-1:0] mask_q, pend_q, act, w1c, vclr, dclr;
  logic [2:0] code;
  logic wr_mask, wr_stat, rd_code;

  assign act = pend_q & mask_q;

  always_comb begin
    code = 3'd0;
    for (int i = NEV - 1; i >= 0; i--)
      if (act[i]) code = 3'(i + 1);
  end

  assign wr_mask = reg_wr && reg_addr == A_MASK;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign rd_code = reg_rd && reg_addr == A_CODE;

  assign w1c  = wr_stat ? reg_wdata[NEV-1:0] : '0;
  assign vclr = (rd_code && code != 3'd0) ?
                ((NEV'(1) << (code - 3'd1)) & ~DATA_EV) : '0;
  assign dclr = {2'b00, tx_loaded, rx_taken, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= evt | (pend_q & ~(w1c | vclr | dclr));
      if (wr_mask) mask_q <= reg_wdata[NEV-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MASK: reg_rdata[NEV-1:0] = mask_q;
      A_STAT: begin
        reg_rdata[NEV-1:0] = pend_q;
        reg_rdata[RSF_BIT] = rx_shift_full;
        reg_rdata[BB_BIT]  = bus_busy;
      end
      A_CODE: reg_rdata[2:0] = code;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_code = code;
  assign irq = code != 3'd0;

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    |evt |=> ((pend_q & $past(evt)) == $past(evt)));

  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q) == '0) |-> (irq_code == 3'd0 && !irq));

  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((pend_q & $past(reg_wdata[NEV-1:0] & ~evt)) == '0));

  a_r6_code_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_code && irq_code != 3'd0 && !DATA_EV[irq_code - 3'd1] && !evt[irq_code - 3'd1])
    |=> !pend_q[$past(irq_code) - 3'd1]);

  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[3] && !rx_taken && !(wr_stat && reg_wdata[3])) |=> pend_q[3]);

  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[4] && !tx_loaded && !(wr_stat && reg_wdata[4])) |=> pend_q[4]);
endmodule

// File: tb/twi_irq_vector_tb.sv
module twi_irq_vector_tb_top;
  logic clk = 0, rst_n = 0;
  logic [6:0] evt = 0;
  logic rx_taken = 0, tx_loaded = 0, rx_shift_full = 0, bus_busy = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [2:0] irq_code;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  twi_irq_vector dut_i (.clk, .rst_n, .evt, .rx_taken, .tx_loaded, .rx_shift_full,
    .bus_busy, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata, .irq_code, .irq);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic [6:0] e, input logic wr, input logic rd,
                     input logic [1:0] a, input logic [15:0] wd,
                     input logic rt, input logic tl, output logic [15:0] rv);
    @(negedge clk);
    evt = e; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    rx_taken = rt; tx_loaded = tl;
    #1 rv = reg_rdata;
    @(posedge clk); #1;
    evt = 0; reg_wr = 0; reg_rd = 0; rx_taken = 0; tx_loaded = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    logic [15:0] v; cyc(0, 1, 0, a, d, 0, 0, v);
  endtask
  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    cyc(0, 0, 1, a, 0, 0, 0, v);
  endtask
  task automatic pulse(input logic [6:0] e);
    logic [15:0] v; cyc(e, 0, 0, 0, 0, 0, 0, v);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 code", {13'd0, irq_code}, 0);
    chk("R1 irq", {15'd0, irq}, 0);
    rd(1, v); chk("R1 status", v, 0);
    rd(0, v); chk("R1 mask", v, 0);
  endtask

  task automatic t_capture_mask;
    logic [15:0] v;
    pulse(7'b0100000);
    rd(1, v); chk("R2 status stop", v, 16'h0020);
    chk("R4 masked code", {13'd0, irq_code}, 0);
    chk("R4 masked irq", {15'd0, irq}, 0);
    wr(0, 16'h007F);
    chk("R3 code stop", {13'd0, irq_code}, 6);
    chk("R4 irq high", {15'd0, irq}, 1);
  endtask

  task automatic t_priority_drain;
    logic [15:0] v;
    pulse(7'b1000101);
    chk("R3 arb wins", {13'd0, irq_code}, 1);
    rd(2, v); chk("R6 read 1", v, 1);
    chk("R6 next 3", {13'd0, irq_code}, 3);
    rd(2, v); chk("R6 read 3", v, 3);
    rd(2, v); chk("R6 read 6", v, 6);
    rd(2, v); chk("R6 read 7", v, 7);
    chk("R4 drained", {15'd0, irq}, 0);
    rd(2, v); chk("R4 read idle", v, 0);
  endtask

  task automatic t_w1c;
    logic [15:0] v;
    pulse(7'b0000011);
    wr(1, 16'h0001);
    rd(1, v); chk("R5 w1c one", v, 16'h0002);
    wr(1, 16'h0000);
    rd(1, v); chk("R5 zero keeps", v, 16'h0002);
    wr(0, 16'h0040);
    pulse(7'b1000000);
    chk("R3 mask selects 7", {13'd0, irq_code}, 7);
    wr(0, 16'h007F);
    wr(1, 16'h007F);
    rd(1, v); chk("R5 all clear", v, 0);
  endtask

  task automatic t_data_flags;
    logic [15:0] v;
    pulse(7'b0011000);
    rd(2, v); chk("R7 read 4", v, 4);
    chk("R7 rx stays", {13'd0, irq_code}, 4);
    cyc(0, 0, 0, 0, 0, 1, 0, v);
    chk("R7 rx_taken", {13'd0, irq_code}, 5);
    rd(2, v); chk("R7 read 5", v, 5);
    chk("R7 tx stays", {13'd0, irq_code}, 5);
    cyc(0, 0, 0, 0, 0, 0, 1, v);
    chk("R7 tx_loaded", {13'd0, irq_code}, 0);
  endtask

  task automatic t_levels;
    logic [15:0] v;
    rx_shift_full = 1; bus_busy = 1;
    rd(1, v); chk("R8 levels", v, 16'h1800);
    wr(1, 16'h1800);
    rd(1, v); chk("R8 write ignored", v, 16'h1800);
    chk("R8 no code", {13'd0, irq_code}, 0);
    rx_shift_full = 0; bus_busy = 0;
  endtask

  task automatic t_collision;
    logic [15:0] v;
    pulse(7'b0000010);
    cyc(7'b0000010, 1, 0, 1, 16'h0002, 0, 0, v);
    rd(1, v); chk("R9 set wins w1c", v, 16'h0002);
    cyc(7'b0000010, 0, 1, 2, 0, 0, 0, v);
    chk("R9 set wins read", {13'd0, irq_code}, 2);
    rd(2, v); chk("R6 read 2", v, 2);
    chk("R6 empty", {13'd0, irq_code}, 0);
  endtask

  task automatic t_map;
    logic [15:0] v;
    wr(0, 16'hFFFF);
    rd(0, v); chk("R10 mask width", v, 16'h007F);
    pulse(7'b0000100);
    wr(2, 16'hFFFF);
    chk("R10 code write ignored", {13'd0, irq_code}, 3);
    rd(1, v); chk("R10 code write no clear", v, 16'h0004);
    rd(3, v); chk("R10 addr3", v, 0);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_capture_mask;
    t_priority_drain;
    t_w1c;
    t_data_flags;
    t_levels;
    t_collision;
    t_map;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule